// File: doc/BRIEF.md
# Pipelined External Memory Request Controller

This block sits between five request channels and a single pipelined external memory port. Two CPU channels issue reads only, two CPU channels issue writes only, and one DMA channel issues either. Each cycle the block chooses at most one request by fixed priority and drives it onto the memory port, provided one of its in-flight slots is free. Every ready pulse from the memory is steered back, in the same cycle, to the channel that owns the oldest outstanding request.

CPU writes never wait for the memory. They are acknowledged in the cycle they are presented, as long as the posted-write queue has room, and then leave that queue in arrival order as an ordinary issue source. A pending counter and two slot state machines track the requests already sent to memory. An abort input cancels everything in flight in one cycle and leaves the queued writes untouched.

Top module: `xmem_req_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `mem_req_o`, every grant, every done and both write acknowledges are low, and `issue_ok_o` is high.
- R2: Issue priority from highest to lowest is: posted-write queue, DMA, read channel C, read channel D. At most one grant is high per cycle. A grant is high in the same cycle as `mem_req_o`, which carries that source's address, write flag and write data.
- R3: At most two requests are outstanding. With two outstanding, `issue_ok_o` is low and `mem_req_o` stays low, even in a cycle that brings a ready.
- R4: A ready completes the oldest outstanding request. In that cycle the done output of its owner pulses and `rd_data_o` equals `mem_rdata_i`. A ready that completes a posted write raises no done output.
- R5: A write on channel E or F is acknowledged in the cycle it is presented when the queue is not full. E wins over F in the same cycle. Queued writes reach memory in the order they were acknowledged, with their own address and data.
- R6: When the posted-write queue is full, no write acknowledge is given.
- R7: While `abort_i` is high, `mem_req_o`, all grants and all done outputs are low, and `mem_cancel_o` is high exactly when a request is outstanding. In the next cycle nothing is outstanding and `issue_ok_o` is high. Queued writes are kept and issued afterwards.
- R8: A request issued in the same cycle as a ready leaves the outstanding count unchanged. A ready with nothing outstanding is ignored: no done output pulses and the count does not wrap.
- R9: A DMA write is completed like a read: `dma_done_o` pulses on its ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_i | input | 1 | Cancel all outstanding memory requests |
| issue_ok_o | output | 1 | A slot is free; a request may be issued |
| mem_cancel_o | output | 1 | Abort seen while requests are outstanding |
| rdc_req_i | input | 1 | Read channel C request |
| rdc_addr_i | input | AW | Read channel C address |
| rdc_gnt_o | output | 1 | Read channel C request issued this cycle |
| rdc_done_o | output | 1 | Read channel C completion |
| rdd_req_i | input | 1 | Read channel D request |
| rdd_addr_i | input | AW | Read channel D address |
| rdd_gnt_o | output | 1 | Read channel D request issued this cycle |
| rdd_done_o | output | 1 | Read channel D completion |
| rd_data_o | output | DW | Read data for the completing request |
| wre_req_i | input | 1 | Write channel E request |
| wre_addr_i | input | AW | Write channel E address |
| wre_data_i | input | DW | Write channel E data |
| wre_ack_o | output | 1 | Write channel E accepted into queue |
| wrf_req_i | input | 1 | Write channel F request |
| wrf_addr_i | input | AW | Write channel F address |
| wrf_data_i | input | DW | Write channel F data |
| wrf_ack_o | output | 1 | Write channel F accepted into queue |
| dma_req_i | input | 1 | DMA request |
| dma_we_i | input | 1 | DMA request is a write |
| dma_addr_i | input | AW | DMA address |
| dma_data_i | input | DW | DMA write data |
| dma_gnt_o | output | 1 | DMA request issued this cycle |
| dma_done_o | output | 1 | DMA completion |
| mem_req_o | output | 1 | Request valid toward memory |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdy_i | input | 1 | Memory completes the oldest request |
| mem_rdata_i | input | DW | Memory read data |

## Verification
The bench builds the block with 8-bit addresses and data and a posted-write queue of depth 2. The shallow queue fills after two acknowledged writes while both slots are busy, so the withheld acknowledge is reached quickly. It also lets queued writes drain through a full slot pair, which tests their ordering against a blocked issue path. The slot count stays at two, so the full-pipeline stall, in-order completion across both slots and an abort with both slots busy all arise in short sequences.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    // Issue sources in priority order: lower value wins
    typedef enum logic [1:0] {
        SRC_WQ  = 2'd0,
        SRC_DMA = 2'd1,
        SRC_RDC = 2'd2,
        SRC_RDD = 2'd3
    } src_e;

    localparam int unsigned NUM_SRC = 4;

    // One in-flight slot toward memory
    typedef struct packed {
        logic busy;
        src_e owner;
        logic we;
    } slot_t;

endpackage

// File: rtl/xmem_arb.sv
module xmem_arb #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0]         req,
    input  logic                 enable,
    output logic [N-1:0]         gnt,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int unsigned IW = $clog2(N);

    // Index 0 has the highest priority
    for (genvar i = 0; i < N; i++) begin : g_gnt
        if (i == 0) begin : g_top
            assign gnt[i] = req[i] & enable;
        end else begin : g_rest
            assign gnt[i] = req[i] & enable & ~(|req[i-1:0]);
        end
    end

    assign any = |gnt;

    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
    end

endmodule

// File: rtl/xmem_wq.sv
module xmem_wq #(
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned EW = AW + DW;

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] ent;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } wq_st_t;

    wq_st_t st_d, st_q;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full      = (st_q.cnt == CW'(DEPTH));
    assign empty     = (st_q.cnt == '0);
    assign head_addr = st_q.ent[st_q.rp][EW-1:DW];
    assign head_data = st_q.ent[st_q.rp][DW-1:0];

    always_comb begin
        logic do_push;
        logic do_pop;
        st_d    = st_q;
        do_push = push & ~full;
        do_pop  = pop & ~empty;
        if (do_push) begin
            st_d.ent[st_q.wp] = {push_addr, push_data};
            st_d.wp           = step_ptr(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = step_ptr(st_q.rp);
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/xmem_slots.sv
module xmem_slots
    import xmem_pkg::*;
#(
    parameter int unsigned NSLOT = 2,
    localparam int unsigned CW   = $clog2(NSLOT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          issue,
    input  src_e          issue_owner,
    input  logic          issue_we,
    input  logic          rdy,
    output logic          can_issue,
    output logic          retire,
    output slot_t         head,
    output logic [CW-1:0] pend
);
    localparam int unsigned PW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    typedef struct packed {
        slot_t [NSLOT-1:0] s;
        logic [PW-1:0]     wp;
        logic [PW-1:0]     rp;
        logic [CW-1:0]     cnt;
    } sl_st_t;

    sl_st_t st_d, st_q;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(NSLOT - 1)) ? '0 : p + PW'(1);
    endfunction

    assign head      = st_q.s[st_q.rp];
    assign pend      = st_q.cnt;
    assign can_issue = (st_q.cnt < CW'(NSLOT));
    // A ready retires the oldest slot only when it is occupied
    assign retire    = rdy & head.busy & ~abort;

    always_comb begin
        logic do_issue;
        st_d     = st_q;
        do_issue = issue & can_issue & ~abort;
        if (abort) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (retire && st_q.rp == PW'(i)) begin
                    st_d.s[i] = '0;
                end
                if (do_issue && st_q.wp == PW'(i)) begin
                    st_d.s[i].busy  = 1'b1;
                    st_d.s[i].owner = issue_owner;
                    st_d.s[i].we    = issue_we;
                end
            end
            if (do_issue) st_d.wp = step_ptr(st_q.wp);
            if (retire)   st_d.rp = step_ptr(st_q.rp);
            st_d.cnt = st_q.cnt + CW'(do_issue) - CW'(retire);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/xmem_req_ctrl.sv
module xmem_req_ctrl
    import xmem_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 16,
    parameter int unsigned WQ_DEPTH = 4,
    parameter int unsigned NSLOT    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort_i,
    output logic          issue_ok_o,
    output logic          mem_cancel_o,
    input  logic          rdc_req_i,
    input  logic [AW-1:0] rdc_addr_i,
    output logic          rdc_gnt_o,
    output logic          rdc_done_o,
    input  logic          rdd_req_i,
    input  logic [AW-1:0] rdd_addr_i,
    output logic          rdd_gnt_o,
    output logic          rdd_done_o,
    output logic [DW-1:0] rd_data_o,
    input  logic          wre_req_i,
    input  logic [AW-1:0] wre_addr_i,
    input  logic [DW-1:0] wre_data_i,
    output logic          wre_ack_o,
    input  logic          wrf_req_i,
    input  logic [AW-1:0] wrf_addr_i,
    input  logic [DW-1:0] wrf_data_i,
    output logic          wrf_ack_o,
    input  logic          dma_req_i,
    input  logic          dma_we_i,
    input  logic [AW-1:0] dma_addr_i,
    input  logic [DW-1:0] dma_data_i,
    output logic          dma_gnt_o,
    output logic          dma_done_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_rdy_i,
    input  logic [DW-1:0] mem_rdata_i
);
    localparam int unsigned CW = $clog2(NSLOT + 1);
    localparam int unsigned IW = $clog2(NUM_SRC);

    logic                wq_full, wq_empty, wq_push;
    logic [AW-1:0]       wq_addr, wq_push_addr;
    logic [DW-1:0]       wq_data, wq_push_data;
    logic [NUM_SRC-1:0]  src_req, src_gnt, done_vec;
    logic                any_gnt, can_issue, retire;
    logic [IW-1:0]       win_idx;
    slot_t               head;
    logic [CW-1:0]       pend_cnt;

    // Posted writes: E takes the queue entry before F
    assign wre_ack_o    = wre_req_i & ~wq_full;
    assign wrf_ack_o    = wrf_req_i & ~wre_req_i & ~wq_full;
    assign wq_push      = wre_ack_o | wrf_ack_o;
    assign wq_push_addr = wre_req_i ? wre_addr_i : wrf_addr_i;
    assign wq_push_data = wre_req_i ? wre_data_i : wrf_data_i;

    xmem_wq #(
        .AW    (AW),
        .DW    (DW),
        .DEPTH (WQ_DEPTH)
    ) u_wq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wq_push),
        .push_addr (wq_push_addr),
        .push_data (wq_push_data),
        .pop       (src_gnt[SRC_WQ]),
        .full      (wq_full),
        .empty     (wq_empty),
        .head_addr (wq_addr),
        .head_data (wq_data)
    );

    always_comb begin
        src_req          = '0;
        src_req[SRC_WQ]  = ~wq_empty;
        src_req[SRC_DMA] = dma_req_i;
        src_req[SRC_RDC] = rdc_req_i;
        src_req[SRC_RDD] = rdd_req_i;
    end

    xmem_arb #(
        .N (NUM_SRC)
    ) u_arb (
        .req    (src_req),
        .enable (can_issue & ~abort_i),
        .gnt    (src_gnt),
        .any    (any_gnt),
        .idx    (win_idx)
    );

    xmem_slots #(
        .NSLOT (NSLOT)
    ) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (abort_i),
        .issue       (any_gnt),
        .issue_owner (src_e'(win_idx)),
        .issue_we    (mem_we_o),
        .rdy         (mem_rdy_i),
        .can_issue   (can_issue),
        .retire      (retire),
        .head        (head),
        .pend        (pend_cnt)
    );

    // Memory-side request mux
    always_comb begin
        mem_req_o   = any_gnt;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (src_e'(win_idx))
            SRC_WQ: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = wq_addr;
                mem_wdata_o = wq_data;
            end
            SRC_DMA: begin
                mem_we_o    = dma_we_i;
                mem_addr_o  = dma_addr_i;
                mem_wdata_o = dma_data_i;
            end
            SRC_RDC: mem_addr_o = rdc_addr_i;
            SRC_RDD: mem_addr_o = rdd_addr_i;
            default: ;
        endcase
    end

    assign issue_ok_o   = can_issue;
    assign mem_cancel_o = abort_i & (pend_cnt != '0);

    // Completion routing to the owner of the oldest slot
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_done
        if (k == SRC_WQ) begin : g_posted
            assign done_vec[k] = 1'b0;
        end else begin : g_owned
            assign done_vec[k] = retire & (head.owner == src_e'(k));
        end
    end

    assign dma_done_o = done_vec[SRC_DMA];
    assign rdc_done_o = done_vec[SRC_RDC];
    assign rdd_done_o = done_vec[SRC_RDD];
    assign rd_data_o  = mem_rdata_i;

    assign dma_gnt_o  = src_gnt[SRC_DMA];
    assign rdc_gnt_o  = src_gnt[SRC_RDC];
    assign rdd_gnt_o  = src_gnt[SRC_RDD];

endmodule

// File: rtl/xmem_req_ctrl_chk.sv
module xmem_req_ctrl_chk #(
    parameter int unsigned NSLOT = 2,
    localparam int unsigned CW   = $clog2(NSLOT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          abort_i,
    input logic          issue_ok_o,
    input logic          mem_cancel_o,
    input logic          mem_req_o,
    input logic          mem_rdy_i,
    input logic [CW-1:0] pend,
    input logic          dma_gnt_o,
    input logic          rdc_gnt_o,
    input logic          rdd_gnt_o,
    input logic          dma_done_o,
    input logic          rdc_done_o,
    input logic          rdd_done_o,
    input logic          wre_req_i,
    input logic          wrf_req_i,
    input logic          wrf_ack_o
);

    AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= CW'(NSLOT)); // R3

    AST_REQ_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> issue_ok_o); // R3

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_gnt_o, rdc_gnt_o, rdd_gnt_o})); // R2

    AST_GRANT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt_o || rdc_gnt_o || rdd_gnt_o) |-> mem_req_o); // R2

    AST_DONE_FROM_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done_o || rdc_done_o || rdd_done_o) |-> mem_rdy_i); // R4

    AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_done_o, rdc_done_o, rdd_done_o})); // R4

    AST_E_BEFORE_F: assert property (@(posedge clk) disable iff (!rst_n)
        (wre_req_i && wrf_req_i) |-> !wrf_ack_o); // R5

    AST_ABORT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |-> !mem_req_o); // R7

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (pend == '0)); // R7

    AST_CANCEL_ONLY_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cancel_o |-> abort_i); // R7

    AST_COUNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rdy_i && pend != '0 && !abort_i) |=> (pend == $past(pend))); // R8

endmodule

bind xmem_req_ctrl xmem_req_ctrl_chk #(
    .NSLOT (NSLOT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort_i      (abort_i),
    .issue_ok_o   (issue_ok_o),
    .mem_cancel_o (mem_cancel_o),
    .mem_req_o    (mem_req_o),
    .mem_rdy_i    (mem_rdy_i),
    .pend         (pend_cnt),
    .dma_gnt_o    (dma_gnt_o),
    .rdc_gnt_o    (rdc_gnt_o),
    .rdd_gnt_o    (rdd_gnt_o),
    .dma_done_o   (dma_done_o),
    .rdc_done_o   (rdc_done_o),
    .rdd_done_o   (rdd_done_o),
    .wre_req_i    (wre_req_i),
    .wrf_req_i    (wrf_req_i),
    .wrf_ack_o    (wrf_ack_o)
);

// File: tb/tb_xmem_req_ctrl.sv
module tb_xmem_req_ctrl;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic abort_i = 1'b0;
    logic issue_ok_o, mem_cancel_o;
    logic rdc_req_i = 1'b0, rdd_req_i = 1'b0;
    logic [AW-1:0] rdc_addr_i = '0, rdd_addr_i = '0;
    logic rdc_gnt_o, rdc_done_o, rdd_gnt_o, rdd_done_o;
    logic [DW-1:0] rd_data_o;
    logic wre_req_i = 1'b0, wrf_req_i = 1'b0;
    logic [AW-1:0] wre_addr_i = '0, wrf_addr_i = '0;
    logic [DW-1:0] wre_data_i = '0, wrf_data_i = '0;
    logic wre_ack_o, wrf_ack_o;
    logic dma_req_i = 1'b0, dma_we_i = 1'b0;
    logic [AW-1:0] dma_addr_i = '0;
    logic [DW-1:0] dma_data_i = '0;
    logic dma_gnt_o, dma_done_o;
    logic mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic mem_rdy_i = 1'b0;
    logic [DW-1:0] mem_rdata_i = '0;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } issue_t;

    issue_t exp_q[$];

    always #5 clk = ~clk;

    xmem_req_ctrl #(.AW(AW), .DW(DW), .WQ_DEPTH(2), .NSLOT(2)) dut (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
        .issue_ok_o(issue_ok_o), .mem_cancel_o(mem_cancel_o),
        .rdc_req_i(rdc_req_i), .rdc_addr_i(rdc_addr_i), .rdc_gnt_o(rdc_gnt_o), .rdc_done_o(rdc_done_o),
        .rdd_req_i(rdd_req_i), .rdd_addr_i(rdd_addr_i), .rdd_gnt_o(rdd_gnt_o), .rdd_done_o(rdd_done_o),
        .rd_data_o(rd_data_o),
        .wre_req_i(wre_req_i), .wre_addr_i(wre_addr_i), .wre_data_i(wre_data_i), .wre_ack_o(wre_ack_o),
        .wrf_req_i(wrf_req_i), .wrf_addr_i(wrf_addr_i), .wrf_data_i(wrf_data_i), .wrf_ack_o(wrf_ack_o),
        .dma_req_i(dma_req_i), .dma_we_i(dma_we_i), .dma_addr_i(dma_addr_i), .dma_data_i(dma_data_i),
        .dma_gnt_o(dma_gnt_o), .dma_done_o(dma_done_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdy_i(mem_rdy_i), .mem_rdata_i(mem_rdata_i)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver side: expected memory issue for the current cycle
    task automatic expect_issue(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_q.push_back('{we: we, addr: a, data: d});
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic mid();
        @(negedge clk);
    endtask

    // Scoreboard monitor: every issue on the memory port must match the front item
    always @(negedge clk) begin
        if (rst_n && (mem_req_o || exp_q.size() > 0)) begin
            checks++;
            if (!mem_req_o) begin
                errors++;
                $display("FAIL R2 issue missing: actual mem_req 0 expected addr %0h", exp_q[0].addr);
                void'(exp_q.pop_front());
            end else if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3 unexpected issue: actual addr %0h expected none", mem_addr_o);
            end else begin
                issue_t e;
                e = exp_q.pop_front();
                if (mem_we_o !== e.we || mem_addr_o !== e.addr || (e.we && mem_wdata_o !== e.data)) begin
                    errors++;
                    $display("FAIL R2/R5 issue: actual we %0b addr %0h data %0h expected we %0b addr %0h data %0h",
                             mem_we_o, mem_addr_o, mem_wdata_o, e.we, e.addr, e.data);
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(posedge clk);
        mid();
        check("R1 mem_req in reset", mem_req_o, 0);
        check("R1 issue_ok in reset", issue_ok_o, 1);
        cyc(); rst_n = 1'b1;
        mid();
        check("R1 grants/dones/acks after reset",
              {dma_gnt_o, rdc_gnt_o, rdd_gnt_o, dma_done_o, rdc_done_o, rdd_done_o, wre_ack_o, wrf_ack_o}, 0);

        // R2 priority DMA > C > D, R3 full pipeline, R4 in-order completion
        cyc(); dma_req_i = 1; dma_we_i = 0; dma_addr_i = 8'h10;
        rdc_req_i = 1; rdc_addr_i = 8'h20; rdd_req_i = 1; rdd_addr_i = 8'h30;
        expect_issue(0, 8'h10, 0);
        mid(); check("R2 DMA wins", {dma_gnt_o, rdc_gnt_o, rdd_gnt_o}, 3'b100);
        cyc(); dma_req_i = 0; expect_issue(0, 8'h20, 0);
        mid(); check("R2 C over D", {rdc_gnt_o, rdd_gnt_o}, 2'b10);
        cyc(); rdc_req_i = 0;
        mid(); check("R3 issue_ok low with two pending", issue_ok_o, 0);
        check("R3 D held back", rdd_gnt_o, 0);
        cyc(); mem_rdy_i = 1; mem_rdata_i = 8'hA5;
        mid(); check("R4 first ready to DMA", {dma_done_o, rdc_done_o, rdd_done_o}, 3'b100);
        check("R4 read data passthrough", rd_data_o, 8'hA5);
        check("R3 no issue in ready cycle when full", mem_req_o, 0);
        cyc(); mem_rdy_i = 0; expect_issue(0, 8'h30, 0);
        mid(); check("R2 D issued once slot frees", rdd_gnt_o, 1);
        cyc(); rdd_req_i = 0; mem_rdy_i = 1;
        mid(); check("R4 second ready to C", {dma_done_o, rdc_done_o, rdd_done_o}, 3'b010);
        cyc();
        mid(); check("R4 third ready to D", {dma_done_o, rdc_done_o, rdd_done_o}, 3'b001);
        cyc();
        mid(); check("R8 stray ready ignored", {dma_done_o, rdc_done_o, rdd_done_o}, 3'b000);
        cyc(); mem_rdy_i = 0;
        mid(); check("R8 count did not wrap", issue_ok_o, 1);

        // R5 posted writes, R6 queue full
        cyc(); wre_req_i = 1; wre_addr_i = 8'h40; wre_data_i = 8'h11;
        wrf_req_i = 1; wrf_addr_i = 8'h50; wrf_data_i = 8'h22;
        mid(); check("R5 E wins ack over F", {wre_ack_o, wrf_ack_o}, 2'b10);
        cyc(); wre_req_i = 0; expect_issue(1, 8'h40, 8'h11);
        mid(); check("R5 F acked next", wrf_ack_o, 1);
        cyc(); wrf_req_i = 0; expect_issue(1, 8'h50, 8'h22);
        mid();
        cyc(); wre_req_i = 1; wre_addr_i = 8'h60; wre_data_i = 8'h33;
        mid(); check("R5 ack while slots full", wre_ack_o, 1);
        cyc(); wre_addr_i = 8'h61; wre_data_i = 8'h34;
        mid(); check("R5 second ack fills queue", wre_ack_o, 1);
        cyc(); wre_addr_i = 8'h62; wre_data_i = 8'h35;
        mid(); check("R6 no ack when full", wre_ack_o, 0);
        cyc(); wre_req_i = 0; mem_rdy_i = 1;
        mid(); check("R4 posted write ready raises no done", {dma_done_o, rdc_done_o, rdd_done_o}, 3'b000);
        cyc(); mem_rdy_i = 0; expect_issue(1, 8'h60, 8'h33);
        mid();
        cyc(); mem_rdy_i = 1;
        mid();
        cyc(); mem_rdy_i = 0; expect_issue(1, 8'h61, 8'h34);
        mid();
        cyc(); mem_rdy_i = 1;
        mid();
        cyc();
        mid();
        cyc(); mem_rdy_i = 0;
        mid(); check("R5 queue drained", issue_ok_o, 1);

        // R8 issue and ready together, R9 DMA write completion
        cyc(); rdc_req_i = 1; rdc_addr_i = 8'h70; expect_issue(0, 8'h70, 0);
        mid();
        cyc(); rdc_req_i = 0; rdd_req_i = 1; rdd_addr_i = 8'h71; mem_rdy_i = 1;
        expect_issue(0, 8'h71, 0);
        mid(); check("R8 done with concurrent issue", {rdc_done_o, rdd_gnt_o}, 2'b11);
        cyc(); rdd_req_i = 0; mem_rdy_i = 0;
        dma_req_i = 1; dma_we_i = 1; dma_addr_i = 8'h72; dma_data_i = 8'h44;
        expect_issue(1, 8'h72, 8'h44);
        mid(); check("R8 count held at one", issue_ok_o, 1);
        cyc(); dma_req_i = 0; mem_rdy_i = 1;
        mid(); check("R4 D done", rdd_done_o, 1);
        cyc();
        mid(); check("R9 DMA write done", dma_done_o, 1);
        cyc(); mem_rdy_i = 0;

        // R7 abort
        cyc(); dma_req_i = 1; dma_we_i = 0; dma_addr_i = 8'h80; expect_issue(0, 8'h80, 0);
        mid();
        cyc(); dma_req_i = 0; rdc_req_i = 1; rdc_addr_i = 8'h81; expect_issue(0, 8'h81, 0);
        wre_req_i = 1; wre_addr_i = 8'h82; wre_data_i = 8'h55;
        mid(); check("R5 ack during issue", wre_ack_o, 1);
        cyc(); rdc_req_i = 0; wre_req_i = 0; abort_i = 1; mem_rdy_i = 1;
        mid(); check("R7 cancel with pending", mem_cancel_o, 1);
        check("R7 no done during abort", {dma_done_o, rdc_done_o, rdd_done_o}, 3'b000);
        check("R7 no request during abort", mem_req_o, 0);
        cyc(); abort_i = 0; mem_rdy_i = 0; expect_issue(1, 8'h82, 8'h55);
        mid(); check("R7 slots free after abort", issue_ok_o, 1);
        cyc(); mem_rdy_i = 1;
        mid();
        cyc(); mem_rdy_i = 0; abort_i = 1;
        mid(); check("R7 no cancel when idle", mem_cancel_o, 0);
        cyc(); abort_i = 0;
        mid();
        check("R2 scoreboard empty", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule